// File: doc/BRIEF.md
# Write-Zero-to-Clear Interrupt Status Register

This block collects single-cycle event pulses from the receive and transmit paths of a serial link controller into an 8-bit sticky status register. A captured bit stays set until the host clears it. To clear it, the host writes a 0 to that bit position. Writing a 1 leaves the bit as it is. This lets the host acknowledge one event with a single write, without a read-modify-write sequence.

The lowest two bits of the register are extension bits. Each one follows a summary input that is already reduced from a secondary status register. A write to the status register never clears them.

An 8-bit mask register sits beside the status register, one mask bit per status bit. The block drives a registered interrupt output that is high when any status bit is set and its mask bit is clear.

The host uses a small bus with four parts: a write strobe, a read strobe, a one-bit register select, and 8-bit write data. Registered read data comes back on the cycle after the read strobe.

Top module: `isr_w0c_status`

## Requirements
- R1: After reset all event bits are 0, the mask register is 0xFF (every source masked) and `irq_o` is 0.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k+2 at the next clock edge. The bit stays set through idle cycles until the host clears it.
- R3: A write to the status register (`addr_i`=0) clears each event bit written as 0 and keeps each bit written as 1. The message-end event (`evt_i[5]`, bit 7) is cleared by writing 0x7F. The block-ready event (`evt_i[4]`, bit 6) is cleared by writing 0xBF. Writing 0xFF changes nothing.
- R4: When an event pulse and a write of 0 to the same bit occur in the same cycle, the bit ends up set.
- R5: Status bits 1:0 read as the current values of `ext_i[1:0]`. Writes to the status register have no effect on them.
- R6: A set mask bit keeps its status bit from raising `irq_o`. The status bit is still set by its event and is still readable.
- R7: `irq_o` equals the OR over all bits of (status AND NOT mask), as registered at the clock edge after that condition is present.
- R8: A read strobe returns, at the next clock edge, the status register (`addr_i`=0) or the mask register (`addr_i`=1) on `rdata_o`. `rdata_o` holds its value when no read is strobed.
- R9: A write with `addr_i`=1 loads `wdata_i` into the mask register and does not change the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 6 | Event pulses; bit k sets status bit k+2 |
| ext_i | input | 2 | Summaries of the secondary status registers |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 1 | Register select: 0 selects status, 1 selects mask |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered host read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed due time, counted from the clock edge that samples the stimulus:
- An event pulse or a status write changes the register at that same edge.
- A read result appears on `rdata_o` one edge after the strobe.
- `irq_o` follows a change in status or mask one edge later than the register does.

The bench drives inputs and samples outputs on the falling edge. A read pushes its expected value into a queue. A monitor pops that value on the falling edge after the sampling rising edge and compares it with `rdata_o`. Interrupt checks are placed one falling edge after the status or mask change has settled. A separate check confirms that the interrupt has not yet moved one edge earlier.

// File: rtl/isr_pkg.sv
// Package isr_pkg
// Purpose : widths and register-select codes shared by the interrupt
//           status register block and its checker.
// Assumes : an 8-bit register whose two lowest bits are extension bits.
package isr_pkg;
    localparam int REG_W = 8;
    localparam int EXT_W = 2;
    localparam int EVT_W = REG_W - EXT_W;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/isr_event_bit.sv
// Module isr_event_bit
// Purpose : one sticky event flag. A set request wins over a clear
//           request that arrives in the same cycle.
// Assumes : set_i and clr_i are synchronous to clk.
module isr_event_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the flag; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/isr_host_port.sv
// Module isr_host_port
// Purpose : decodes host writes into per-bit clear requests and mask
//           loads, holds the mask register, and returns registered
//           read data.
// Assumes : a single-cycle write or read strobe; reading has no side
//           effects.
module isr_host_port
    import isr_pkg::*;
#(
    parameter int           P_REG_W    = REG_W,
    parameter int           P_EXT_W    = EXT_W,
    parameter logic [P_REG_W-1:0] P_MASK_RST = '1,
    localparam int          P_EVT_W    = P_REG_W - P_EXT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic               addr_i,
    input  logic [P_REG_W-1:0] wdata_i,
    input  logic [P_REG_W-1:0] status_view_i,
    output logic [P_EVT_W-1:0] evt_clr_o,
    output logic [P_REG_W-1:0] mask_o,
    output logic [P_REG_W-1:0] rdata_o
);
    logic wr_status;
    logic wr_mask;

    // Decode a host write into its target register.
    always_comb begin
        wr_status = wr_en_i && (reg_sel_e'(addr_i) == SEL_STATUS);
        wr_mask   = wr_en_i && (reg_sel_e'(addr_i) == SEL_MASK);
    end

    // A 0 written to an event position becomes a clear request.
    always_comb begin
        evt_clr_o = wr_status ? ~wdata_i[P_REG_W-1:P_EXT_W] : '0;
    end

    // Mask register: loaded whole by a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= P_MASK_RST;
        else if (wr_mask) mask_o <= wdata_i;
    end

    // Read data register: updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_en_i)
            rdata_o <= (reg_sel_e'(addr_i) == SEL_MASK) ? mask_o : status_view_i;
    end
endmodule

// File: rtl/isr_irq_gen.sv
// Module isr_irq_gen
// Purpose : registered interrupt request; high when any status bit is
//           set while its mask bit is clear.
// Assumes : status and mask have the same width and bit order.
module isr_irq_gen #(
    parameter int P_REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_REG_W-1:0] status_i,
    input  logic [P_REG_W-1:0] mask_i,
    output logic               irq_o
);
    logic pending;

    // Reduce the unmasked status bits to one pending flag.
    always_comb begin
        pending = |(status_i & ~mask_i);
    end

    // Register the request so irq_o is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending;
    end
endmodule

// File: rtl/isr_w0c_status.sv
// Module isr_w0c_status (top)
// Purpose : 8-bit interrupt status register. Event pulses set sticky
//           bits 7:2, the host clears a bit by writing 0 to it, bits
//           1:0 follow the secondary-register summaries, and a mask
//           register gates the registered interrupt output.
// Assumes : evt_i pulses are synchronous to clk; ext_i is already a
//           masked summary of each secondary register.
module isr_w0c_status
    import isr_pkg::*;
#(
    parameter int           REG_W_P  = REG_W,
    parameter int           EXT_W_P  = EXT_W,
    parameter logic [7:0]   MASK_RST = 8'hFF,
    localparam int          EVT_W_P  = REG_W_P - EXT_W_P
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W_P-1:0] evt_i,
    input  logic [EXT_W_P-1:0] ext_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic               addr_i,
    input  logic [REG_W_P-1:0] wdata_i,
    output logic [REG_W_P-1:0] rdata_o,
    output logic               irq_o
);
    logic [EVT_W_P-1:0] evt_q;
    logic [EVT_W_P-1:0] evt_clr;
    logic [REG_W_P-1:0] mask_q;
    logic [REG_W_P-1:0] status_view;

    // Build the register as the host sees it: events above, extensions below.
    always_comb begin
        status_view = {evt_q, ext_i};
    end

    // One sticky flag per event position.
    for (genvar g = 0; g < EVT_W_P; g++) begin : g_evt
        isr_event_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_i[g]),
            .clr_i (evt_clr[g]),
            .q_o   (evt_q[g])
        );
    end

    isr_host_port #(
        .P_REG_W    (REG_W_P),
        .P_EXT_W    (EXT_W_P),
        .P_MASK_RST (MASK_RST[REG_W_P-1:0])
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .rd_en_i       (rd_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .status_view_i (status_view),
        .evt_clr_o     (evt_clr),
        .mask_o        (mask_q),
        .rdata_o       (rdata_o)
    );

    isr_irq_gen #(
        .P_REG_W (REG_W_P)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_view),
        .mask_i   (mask_q),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/isr_w0c_chk.sv
// Module isr_w0c_chk
// Purpose : temporal checks on the status register. It is bound into
//           isr_w0c_status and reads its event flags and mask register.
// Assumes : the default register layout of isr_pkg.
module isr_w0c_chk #(
    parameter int P_REG_W = 8,
    parameter int P_EXT_W = 2,
    localparam int P_EVT_W = P_REG_W - P_EXT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [P_EVT_W-1:0] evt_i,
    input logic [P_EXT_W-1:0] ext_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic               addr_i,
    input logic [P_REG_W-1:0] wdata_i,
    input logic [P_REG_W-1:0] rdata_o,
    input logic               irq_o,
    input logic [P_EVT_W-1:0] evt_q,
    input logic [P_REG_W-1:0] mask_q
);
    // R2: with no status write, set flags stay set.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en_i && !addr_i)) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    // R3: a status write keeps exactly the bits written as 1, plus new events.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i) |=>
        (evt_q == (($past(evt_q) & $past(wdata_i[P_REG_W-1:P_EXT_W])) | $past(evt_i))));

    // R4: every pulsed event is set on the next cycle, whatever was written.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((evt_q & $past(evt_i)) == $past(evt_i)));

    // R5: a status read returns the extension inputs in bits 1:0.
    p_ext_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !addr_i) |=> (rdata_o[P_EXT_W-1:0] == $past(ext_i)));

    // R7: the interrupt follows the unmasked status one edge later.
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == (|($past({evt_q, ext_i}) & ~$past(mask_q)))));

    // R9: a mask write loads the mask register.
    p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i) |=> (mask_q == $past(wdata_i)));
endmodule

bind isr_w0c_status isr_w0c_chk #(
    .P_REG_W (REG_W_P),
    .P_EXT_W (EXT_W_P)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .ext_i   (ext_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .evt_q   (evt_q),
    .mask_q  (mask_q)
);

// File: tb/isr_w0c_status_tb.sv
// Scoreboard bench for isr_w0c_status.
// Inputs are driven on the falling edge. Each read pushes an expected item
// into a queue; a falling-edge monitor pops the item and compares it one
// edge after the strobe.
module isr_w0c_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_i = '0;
    logic [1:0] ext_i = '0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic       addr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t   sb_q[$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    isr_w0c_status u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .ext_i   (ext_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Note which rising edges sampled a read strobe.
    always @(posedge clk) rd_seen <= rd_en_i;

    // Monitor: compare read data one edge after the strobe.
    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (rdata_o !== it.exp) begin
                n_fails++;
                $display("FAIL %s: rdata actual=0x%02h expected=0x%02h", it.tag, rdata_o, it.exp);
            end
        end
    end

    task automatic chk_irq(input logic exp, input string tag);
        n_checks++;
        if (irq_o !== exp) begin
            n_fails++;
            $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq_o, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        rd_en_i = 1'b1;
        addr_i  = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(20 * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        chk_irq(1'b0, "R1 irq");
        rd(1'b0, 8'h00, "R1 status");
        rd(1'b1, 8'hFF, "R1 mask");

        // R2, R6: events set bits even while masked
        pulse(6'b110000);
        rd(1'b0, 8'hC0, "R2 set");
        chk_irq(1'b0, "R6 masked");
        idle(5);
        rd(1'b0, 8'hC0, "R2 sticky");

        // R3: write-zero clears, write-one keeps
        wr(1'b0, 8'h7F);
        rd(1'b0, 8'h40, "R3 0x7F");
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h40, "R3 0xFF");
        wr(1'b0, 8'hBF);
        rd(1'b0, 8'h00, "R3 0xBF");

        // R9: mask load and read back
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R9 mask");
        rd(1'b0, 8'h00, "R9 status");

        // R7: irq registered one edge after the bit sets
        pulse(6'b000001);
        chk_irq(1'b0, "R7 not yet");
        @(negedge clk);
        chk_irq(1'b1, "R7 asserted");
        wr(1'b0, 8'hFB);
        chk_irq(1'b1, "R7 hold");
        @(negedge clk);
        chk_irq(1'b0, "R7 dropped");

        // R4: set beats a same-cycle clear
        evt_i = 6'b100000;
        wr(1'b0, 8'h7F);
        evt_i = '0;
        rd(1'b0, 8'h80, "R4 set wins");

        // R5: extension bits follow inputs and ignore writes
        ext_i = 2'b11;
        wr(1'b0, 8'h00);
        rd(1'b0, 8'h03, "R5 ext");
        @(negedge clk);
        chk_irq(1'b1, "R5 ext irq");
        ext_i = 2'b01;
        wr(1'b0, 8'h00);
        rd(1'b0, 8'h01, "R5 ext follow");
        wr(1'b1, 8'h03);
        @(negedge clk);
        chk_irq(1'b0, "R6 ext masked");
        ext_i = 2'b00;

        // R6: full mask suppresses irq, bits still set
        wr(1'b1, 8'hFF);
        pulse(6'b111111);
        idle(2);
        chk_irq(1'b0, "R6 all masked");
        rd(1'b0, 8'hFC, "R6 bits set");
        wr(1'b1, 8'h7F);
        @(negedge clk);
        chk_irq(1'b1, "R6 unmask bit7");
        rd(1'b1, 8'h7F, "R8 mask read");

        // R8: rdata holds without a read strobe
        wr(1'b0, 8'h00);
        idle(2);
        n_checks++;
        if (rdata_o !== 8'h7F) begin
            n_fails++;
            $display("FAIL R8 hold: rdata actual=0x%02h expected=0x%02h", rdata_o, 8'h7F);
        end

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule